// File: doc/BRIEF.md
# Legacy INTx Virtual Wire Aggregator

Several downstream serial-link ports each send in-band, level-style interrupt messages for the four legacy lines A, B, C and D. Each message says "raise line X" or "drop line X". The aggregator keeps a tracking bit for every line on every port. It merges the bits across ports into four virtual wires. It sends its own raise or drop message upstream to the single legacy interrupt controller, and it does this only when one of those wires changes level. The upstream side therefore never sees more than four lines active, however many downstream sources are raising them.

Upstream messages wait in a small FIFO and leave through a valid/ready handshake. A per-line record holds the level most recently queued for each wire. When the FIFO has no room, a wire change is held back and retried. Each retry compares the wire with that record, so the upstream controller always ends up with the current wire levels.

Top module: `intx_aggregator`

## Requirements
- R1: A synchronous reset clears all tracking bits and the FIFO. After reset `vline` is 0 and `up_valid` is 0.
- R2: An accepted message on port P sets bit (P, line) when `msg_assert`=1 and clears it when `msg_assert`=0. The line field decodes 0=A, 1=B, 2=C, 3=D. `vline[X]` is the OR of bit X over all ports and shows the update one clock after the message.
- R3: An upstream raise message for line X is queued when `vline[X]` goes from 0 to 1. A drop message is queued only when bit X is clear on every port.
- R4: A raise for a bit that is already set, or a drop for a bit that is already clear, leaves the state unchanged and queues nothing.
- R5: Messages from different ports in the same cycle are all applied before the wires are compared. A drop on one port together with a raise of the same line on another port, while the wire stays active, queues nothing.
- R6: An upstream message carries `up_line` (0=A .. 3=D) and `up_assert` (1=raise, 0=drop). It becomes visible with `up_valid` the cycle after the input edge that caused it. Changes on several lines in one cycle are queued in the order A, B, C, D.
- R7: The FIFO holds DEPTH (default 8) messages and releases them in arrival order. A raise and a later drop of the same line are both kept while unsent.
- R8: When the FIFO lacks room, a wire change is held back. It is queued on a later cycle with room, provided the wire still differs from the level last queued for that line. If the wire has returned to that level by then, nothing is sent.
- R9: While `up_valid`=1 and `up_ready`=0, `up_valid`, `up_line` and `up_assert` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| msg_valid | input | NPORTS | One message strobe per downstream port |
| msg_line | input | 2*NPORTS | Line index per port, bits [2p+1:2p] for port p |
| msg_assert | input | NPORTS | 1 = raise, 0 = drop, per port |
| vline | output | 4 | Current virtual wire levels, bit 0 = A |
| up_valid | output | 1 | Upstream message available |
| up_ready | input | 1 | Upstream side takes the message |
| up_line | output | 2 | Line of the upstream message |
| up_assert | output | 1 | 1 = raise, 0 = drop |

## Verification
The assertions assume that each port gives at most one message per cycle, which the one-strobe-per-port interface enforces. They also assume that `up_ready` may fall at any time, including while a message is pending. The stall property relies on the consumer never withdrawing a message it has not taken. The bench therefore changes `up_ready` freely but never forces the output. The settled-state and idle properties assume that no input strobe arrives in the checked cycle. The bench includes long idle gaps and full-FIFO stalls so that those conditions actually occur.

// File: rtl/intx_aggregator.sv
module intx_aggregator #(
  parameter int NPORTS = 4,
  parameter int DEPTH  = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NPORTS-1:0]     msg_valid,
  input  logic [2*NPORTS-1:0]   msg_line,
  input  logic [NPORTS-1:0]     msg_assert,
  output logic [3:0]            vline,
  output logic                  up_valid,
  input  logic                  up_ready,
  output logic [1:0]            up_line,
  output logic                  up_assert
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [3:0]    track    [NPORTS];
  logic [3:0]    track_nx [NPORTS];
  logic [3:0]    vw_nx;
  logic [3:0]    qlvl;
  logic [2:0]    mem [DEPTH];
  logic [AW-1:0] wr, rd;
  logic [CW-1:0] count, free;
  logic [3:0]    push;
  logic [AW-1:0] slot [4];
  logic [2:0]    npush;
  logic          pop;

  always_comb begin
    for (int p = 0; p < NPORTS; p++) begin
      track_nx[p] = track[p];
      if (msg_valid[p]) track_nx[p][msg_line[2*p +: 2]] = msg_assert[p];
    end
  end

  always_comb begin
    vw_nx = '0;
    vline = '0;
    for (int p = 0; p < NPORTS; p++) begin
      vw_nx = vw_nx | track_nx[p];
      vline = vline | track[p];
    end
  end

  always_comb begin
    free  = CW'(DEPTH) - count;
    npush = '0;
    for (int i = 0; i < 4; i++) begin
      push[i] = 1'b0;
      slot[i] = wr + AW'(npush);
      if (vw_nx[i] != qlvl[i] && CW'(npush) < free) begin
        push[i] = 1'b1;
        npush   = npush + 3'd1;
      end
    end
  end

  assign up_valid = (count != '0);
  assign pop      = up_valid && up_ready;
  assign {up_line, up_assert} = mem[rd];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NPORTS; p++) track[p] <= '0;
      qlvl  <= '0;
      wr    <= '0;
      rd    <= '0;
      count <= '0;
    end else begin
      for (int p = 0; p < NPORTS; p++) track[p] <= track_nx[p];
      for (int i = 0; i < 4; i++)
        if (push[i]) qlvl[i] <= vw_nx[i];
      wr    <= wr + AW'(npush);
      rd    <= rd + AW'(pop);
      count <= count + CW'(npush) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < 4; i++)
      if (!rst && push[i]) mem[slot[i]] <= {i[1:0], vw_nx[i]};
  end

  initial begin
    assert (DEPTH >= 8 && (1 << AW) == DEPTH) else $error("DEPTH must be a power of two of at least 8");
  end

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (rst)
    up_valid && !up_ready |=> up_valid && $stable({up_line, up_assert})); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R7
  AST_SETTLED: assert property (@(posedge clk) disable iff (rst)
    count == '0 |-> qlvl == vline); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    count == '0 && msg_valid == '0 |=> count == '0 && vline == $past(vline)); // R4
endmodule

// File: tb/intx_aggregator_bench.sv
`timescale 1ns/1ps
module intx_aggregator_bench;
  localparam int NP = 4;
  localparam int DEPTH = 8;

  logic clk = 0;
  logic rst = 1;
  logic [NP-1:0]   msg_valid = '0;
  logic [2*NP-1:0] msg_line = '0;
  logic [NP-1:0]   msg_assert = '0;
  logic [3:0] vline;
  logic up_valid, up_ready = 1'b1, up_assert;
  logic [1:0] up_line;

  intx_aggregator #(.NPORTS(NP), .DEPTH(DEPTH)) u_intx_aggregator (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_line(msg_line),
    .msg_assert(msg_assert), .vline(vline), .up_valid(up_valid),
    .up_ready(up_ready), .up_line(up_line), .up_assert(up_assert));

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  bit trk [NP][4];
  bit mql [4];
  int q [$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int model_vw();
    int v = 0;
    for (int p = 0; p < NP; p++)
      for (int x = 0; x < 4; x++) if (trk[p][x]) v |= (1 << x);
    return v;
  endfunction

  task automatic compare();
    chk(vline == model_vw(), "R2", "vline", vline, model_vw());
    chk(up_valid == (q.size() != 0), "R6", "up_valid", up_valid, q.size() != 0);
    if (q.size() != 0 && up_valid)
      chk({up_line, up_assert} == q[0][2:0], "R7", "head message", {up_line, up_assert}, q[0]);
  endtask

  task automatic model_reset();
    for (int p = 0; p < NP; p++) for (int x = 0; x < 4; x++) trk[p][x] = 0;
    for (int x = 0; x < 4; x++) mql[x] = 0;
    q.delete();
  endtask

  task automatic model_step(logic [NP-1:0] v, logic [2*NP-1:0] l, logic [NP-1:0] a, logic r);
    int fr = DEPTH - q.size();
    bit pp = r && q.size() != 0;
    int np = 0;
    int vw;
    for (int p = 0; p < NP; p++) if (v[p]) trk[p][l[2*p +: 2]] = a[p];
    vw = model_vw();
    for (int x = 0; x < 4; x++) begin
      if (vw[x] != mql[x] && np < fr) begin
        q.push_back(x * 2 + vw[x]);
        mql[x] = vw[x];
        np++;
      end
    end
    if (pp) void'(q.pop_front());
  endtask

  task automatic cyc(logic [NP-1:0] v, logic [2*NP-1:0] l, logic [NP-1:0] a, logic r);
    @(negedge clk);
    compare();
    msg_valid = v; msg_line = l; msg_assert = a; up_ready = r;
    model_step(v, l, a, r);
  endtask

  task automatic idle(logic r);
    cyc('0, '0, '0, r);
  endtask

  task automatic one(int port, int line, bit asrt, logic r);
    logic [NP-1:0] v = '0;
    logic [2*NP-1:0] l = '0;
    logic [NP-1:0] a = '0;
    v[port] = 1'b1;
    l[2*port +: 2] = 2'(line);
    a[port] = asrt;
    cyc(v, l, a, r);
  endtask

  initial begin
    #(100000 * 20);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [1:0] hl;
    logic ha;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(up_valid == 0, "R1", "up_valid after reset", up_valid, 0);
    chk(vline == 0, "R1", "vline after reset", vline, 0);

    // R2 R3: first raise of A
    one(0, 0, 1, 1); idle(1);
    chk(up_valid == 1 && up_line == 0 && up_assert == 1, "R3", "raise A sent", {up_valid, up_line, up_assert}, 4'b1001);
    chk(vline == 4'b0001, "R2", "vline A", vline, 1);
    one(1, 0, 1, 1); idle(1);
    chk(up_valid == 0, "R3", "second port raise A silent", up_valid, 0);
    one(0, 0, 0, 1); idle(1);
    chk(up_valid == 0, "R3", "partial drop A silent", up_valid, 0);
    chk(vline == 4'b0001, "R2", "vline A still on", vline, 1);
    one(1, 0, 0, 1); idle(1);
    chk(up_valid == 1 && up_line == 0 && up_assert == 0, "R3", "drop A sent", {up_valid, up_line, up_assert}, 4'b1000);
    idle(1);

    // R4 idempotent repeats
    one(2, 1, 1, 1); idle(1); idle(1);
    one(2, 1, 1, 1); idle(1);
    chk(up_valid == 0, "R4", "repeat raise B silent", up_valid, 0);
    one(3, 2, 0, 1); idle(1);
    chk(up_valid == 0, "R4", "drop of clear C silent", up_valid, 0);
    chk(vline == 4'b0010, "R4", "vline unchanged", vline, 2);
    one(2, 1, 0, 1); idle(1); idle(1);

    // R5 same-cycle updates: port0 has D, port0 drops while port1 raises
    one(0, 3, 1, 1); idle(1); idle(1);
    cyc(4'b0011, 8'b0000_1111, 4'b0010, 1); idle(1);
    chk(up_valid == 0, "R5", "handover of D silent", up_valid, 0);
    chk(vline == 4'b1000, "R5", "vline D held", vline, 8);
    one(1, 3, 0, 1); idle(1); idle(1);

    // R6 several lines in one cycle, consumer stalled
    cyc(4'b1111, 8'b0001_1011, 4'b1111, 0); idle(0);
    chk(up_valid == 1 && up_line == 0 && up_assert == 1, "R6", "head is A", {up_valid, up_line, up_assert}, 4'b1001);
    repeat (6) idle(1);
    cyc(4'b1111, 8'b0001_1011, 4'b0000, 1);
    repeat (6) idle(1);

    // R7 R8 R9: toggle A with consumer stalled until FIFO fills
    for (int k = 0; k < 12; k++) one(0, 0, (k % 2) == 0, 0);
    idle(0);
    hl = up_line; ha = up_assert;
    for (int k = 0; k < 4; k++) begin
      idle(0);
      chk(up_valid == 1 && up_line == hl && up_assert == ha, "R9", "held while stalled", {up_line, up_assert}, {hl, ha});
    end
    // R8: during full stall, raise and drop B; returns to queued level
    one(1, 1, 1, 0); one(1, 1, 0, 0);
    repeat (12) idle(1);
    chk(up_valid == 0, "R8", "drained, B change netted out", up_valid, 0);
    // R8: deferred change survives
    for (int k = 0; k < 8; k++) one(0, 0, (k % 2) == 0, 0);
    one(2, 2, 1, 0); idle(0);
    repeat (12) idle(1);
    chk(vline == 4'b0100, "R8", "vline C", vline, 4);
    one(2, 2, 0, 1);
    repeat (4) idle(1);

    // random traffic
    for (int k = 0; k < 3000; k++) begin
      logic [NP-1:0] v;
      logic [2*NP-1:0] l;
      logic [NP-1:0] a;
      v = '0;
      for (int p = 0; p < NP; p++) v[p] = ($urandom_range(0, 3) == 0);
      l = 8'($urandom());
      a = 4'($urandom());
      if ((k / 200) % 3 == 2) v = '0;
      cyc(v, l, a, $urandom_range(0, 9) < 7);
    end
    repeat (20) idle(1);
    idle(1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule